// File: doc/BRIEF.md
# Audio Delta-Sigma Bitstream Modulator

This block turns signed PCM audio samples into a single-bit pulse stream. That stream drives one output pin, and an external RC low-pass filter turns it back into an analogue voltage. The block runs on a fast modulator clock, which is the bit rate and lies anywhere from 10 MHz to 300 MHz. An audio-rate strobe, `sample_en`, loads a new sample. The oversampling ratio is the modulator clock divided by the strobe rate.

Two noise-shaping loops are available, chosen by the `ORDER` parameter: a single integrator, or a cascade of two integrators. Each integrator saturates at a fixed bound. This keeps the two-integrator loop stable and lets it recover when it is overdriven. An input, `dither_en`, adds a small pseudo-random offset in front of the one-bit decision. The offset breaks up the idle tones that a loop falls into on constant or very quiet input.

The reset input is asynchronous and active-low. Its release passes through a two-stage synchroniser. While reset is held, the pin stays low.

Top module: `pcm_bitstream_mod`

## Requirements
- R1: While `rst_n` is low, and on the two rising edges after it goes high, `bit_out` is 0. On those edges the integrators hold 0 and the dither generator holds 16'hACE1. The first loop update takes place on the third rising edge after release.
- R2: `sample_in` (16-bit two's complement) is captured only on a rising edge where `sample_en` is 1. The loop uses the captured value from the following edge onward. Changes on `sample_in` while `sample_en` is 0 have no effect on `bit_out`.
- R3: On each active edge, the feedback is +32768 if the current `bit_out` is 1 and −32768 if it is 0. The first integrator becomes its old value plus the held sample minus the feedback.
- R4: With `ORDER`=1, the next `bit_out` is 1 exactly when (new first integrator + dither) ≥ 0. With `ORDER`=2, a second integrator becomes its old value plus the new first-integrator value minus the same feedback. The next `bit_out` is then 1 exactly when (new second integrator + dither) ≥ 0.
- R5: The first integrator saturates to the range [−131072, 131071]. The second integrator saturates to the range [−262144, 262143].
- R6: The dither source is a 16-bit shift register that steps on every active edge. On each step it shifts left by one, and the bit fed into bit 0 is the XOR of bits 15, 13, 12 and 10. The dither value is bits 3:0 of the current state, read as a signed 4-bit number (−8..7).
- R7: When `dither_en` is 0, the dither value is 0. The shift register keeps stepping all the same.
- R8: For a constant sample x, the number of ones in 4096 consecutive settled output bits lies within 6 of (x+32768)/16. With `ORDER`=1 this holds for every x. With `ORDER`=2 it holds for |x| ≤ 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (bit rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sample_en | input | 1 | Load strobe for a new PCM sample |
| sample_in | input | 16 | Signed PCM sample |
| dither_en | input | 1 | Enables the dither offset at the quantiser |
| bit_out | output | 1 | One-bit modulated stream for the output pin |

## Verification
Instances with one integrator and with two are driven side by side. Their output is compared bit for bit against an independent model of the recurrences, so a wrong feedback sign, a wrong summing order or an off-by-one in the sample capture shows up as soon as the streams diverge. The full-scale inputs of both signs drive the second integrator into its clamp. A design that wraps instead of saturating would flip sign there and emit a burst of wrong bits. Some vectors toggle `sample_in` freely between strobes, which exposes a capture register that ignores `sample_en`. The dither vectors and the mid-run reset check the register taps, the seed and the restart, since a wrong seed or tap shifts which cycles the small offset tips a decision.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  localparam int                LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // One step of the maximal-length register: shift left, feedback into bit 0.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/dsm_rst_sync.sv
module dsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dsm_sample_hold.sv
module dsm_sample_hold #(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     srst_n,
  input  logic                     sample_en,
  input  logic signed [DATA_W-1:0] sample_in,
  output logic signed [DATA_W-1:0] held
);

  logic signed [DATA_W-1:0] held_d;

  always_comb held_d = sample_en ? sample_in : held;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) held <= '0;
    else         held <= held_d;
  end

  // R2: the held value moves only on a strobe, and then takes the port value
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !sample_en |=> $stable(held));
  p_hold_load_r2: assert property (@(posedge clk) disable iff (!srst_n)
    sample_en |=> held == $past(sample_in));

endmodule

// File: rtl/dsm_dither_gen.sv
module dsm_dither_gen #(
  parameter int OUT_W     = 20,
  parameter int DITH_BITS = 4
) (
  input  logic                    clk,
  input  logic                    srst_n,
  input  logic                    dither_en,
  output logic signed [OUT_W-1:0] dith
);
  import dsm_pkg::*;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;

  always_comb lfsr_d = lfsr_step(lfsr_q);

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) lfsr_q <= LFSR_SEED;
    else         lfsr_q <= lfsr_d;
  end

  always_comb begin
    if (dither_en)
      dith = {{(OUT_W-DITH_BITS){lfsr_q[DITH_BITS-1]}}, lfsr_q[DITH_BITS-1:0]};
    else
      dith = '0;
  end

  // R6: the register never locks up at zero and advances on every active cycle
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!srst_n)
    lfsr_q != '0);
  p_lfsr_moves_r6: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> lfsr_q != $past(lfsr_q));

endmodule

// File: rtl/dsm_loop.sv
module dsm_loop #(
  parameter int DATA_W = 16,
  parameter int ORDER  = 2,
  parameter int INT_W  = DATA_W + 4
) (
  input  logic                     clk,
  input  logic                     srst_n,
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [INT_W-1:0]  dith,
  output logic                     bit_q
);

  localparam int     SUM_W   = INT_W + 1;
  localparam longint FS_L    = longint'(1) <<< (DATA_W - 1);
  localparam longint SPAN1_L = longint'(1) <<< (DATA_W + 1);
  localparam longint SPAN2_L = longint'(1) <<< (DATA_W + 2);

  localparam logic signed [SUM_W-1:0] FS    = SUM_W'(FS_L);
  localparam logic signed [SUM_W-1:0] I1_HI = SUM_W'(SPAN1_L - 1);
  localparam logic signed [SUM_W-1:0] I1_LO = SUM_W'(-SPAN1_L);
  localparam logic signed [SUM_W-1:0] I2_HI = SUM_W'(SPAN2_L - 1);
  localparam logic signed [SUM_W-1:0] I2_LO = SUM_W'(-SPAN2_L);
  // margins inside which a single step cannot reach the clamp
  localparam logic signed [SUM_W-1:0] M1_HI = SUM_W'(SPAN1_L - 3 * FS_L);
  localparam logic signed [SUM_W-1:0] M1_LO = SUM_W'(-SPAN1_L + 3 * FS_L);
  localparam logic signed [SUM_W-1:0] M2_HI = SUM_W'(SPAN2_L - 6 * FS_L);
  localparam logic signed [SUM_W-1:0] M2_LO = SUM_W'(-SPAN2_L + 6 * FS_L);

  function automatic logic signed [INT_W-1:0] clip(
    input logic signed [SUM_W-1:0] v,
    input logic signed [SUM_W-1:0] lo,
    input logic signed [SUM_W-1:0] hi
  );
    if (v > hi)      return INT_W'(hi);
    else if (v < lo) return INT_W'(lo);
    else             return INT_W'(v);
  endfunction

  logic signed [SUM_W-1:0] x_ext;
  logic signed [SUM_W-1:0] fb;
  logic signed [SUM_W-1:0] i1_sum;
  logic signed [INT_W-1:0] i1_q;
  logic signed [INT_W-1:0] i1_d;
  logic signed [INT_W-1:0] last_d;
  logic signed [SUM_W-1:0] decide;
  logic                    bit_d;

  // first integrator and feedback
  always_comb begin
    x_ext  = SUM_W'(x);
    fb     = bit_q ? FS : -FS;
    i1_sum = SUM_W'(i1_q) + x_ext - fb;
    i1_d   = clip(i1_sum, I1_LO, I1_HI);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) i1_q <= '0;
    else         i1_q <= i1_d;
  end

  generate
    if (ORDER >= 2) begin : g_second
      logic signed [SUM_W-1:0] i2_sum;
      logic signed [INT_W-1:0] i2_q;
      logic signed [INT_W-1:0] i2_d;

      always_comb begin
        i2_sum = SUM_W'(i2_q) + SUM_W'(i1_d) - fb;
        i2_d   = clip(i2_sum, I2_LO, I2_HI);
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n) i2_q <= '0;
        else         i2_q <= i2_d;
      end

      assign last_d = i2_d;

      // R5: second integrator stays inside its saturation window
      p_i2_bound_r5: assert property (@(posedge clk) disable iff (!srst_n)
        SUM_W'(i2_q) <= I2_HI && SUM_W'(i2_q) >= I2_LO);
      // R4: away from the clamp the second stage accumulates i1 minus feedback
      p_i2_step_r4: assert property (@(posedge clk) disable iff (!srst_n)
        (SUM_W'(i2_q) < M2_HI && SUM_W'(i2_q) > M2_LO)
        |=> SUM_W'(i2_q) == SUM_W'($past(i2_q)) + SUM_W'(i1_q) - $past(fb));
    end else begin : g_first
      assign last_d = i1_d;
    end
  endgenerate

  // one-bit quantiser with dither in front of the decision
  always_comb begin
    decide = SUM_W'(last_d) + SUM_W'(dith);
    bit_d  = !decide[SUM_W-1];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) bit_q <= 1'b0;
    else         bit_q <= bit_d;
  end

  // R5: first integrator stays inside its saturation window
  p_i1_bound_r5: assert property (@(posedge clk) disable iff (!srst_n)
    SUM_W'(i1_q) <= I1_HI && SUM_W'(i1_q) >= I1_LO);
  // R3: away from the clamp the first stage adds sample minus feedback
  p_i1_step_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (SUM_W'(i1_q) < M1_HI && SUM_W'(i1_q) > M1_LO)
    |=> SUM_W'(i1_q) == SUM_W'($past(i1_q)) + $past(x_ext) - $past(fb));

endmodule

// File: rtl/pcm_bitstream_mod.sv
module pcm_bitstream_mod #(
  parameter int DATA_W    = 16,
  parameter int ORDER     = 2,
  parameter int DITH_BITS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_en,
  input  logic signed [DATA_W-1:0] sample_in,
  input  logic                     dither_en,
  output logic                     bit_out
);

  localparam int INT_W = DATA_W + 4;

  logic                     srst_n;
  logic signed [DATA_W-1:0] held;
  logic signed [INT_W-1:0]  dith;

  dsm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dsm_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .srst_n    (srst_n),
    .sample_en (sample_en),
    .sample_in (sample_in),
    .held      (held)
  );

  dsm_dither_gen #(.OUT_W(INT_W), .DITH_BITS(DITH_BITS)) u_dith (
    .clk       (clk),
    .srst_n    (srst_n),
    .dither_en (dither_en),
    .dith      (dith)
  );

  dsm_loop #(.DATA_W(DATA_W), .ORDER(ORDER), .INT_W(INT_W)) u_loop (
    .clk    (clk),
    .srst_n (srst_n),
    .x      (held),
    .dith   (dith),
    .bit_q  (bit_out)
  );

  // R1: pin is held low while the synchronised reset is active
  p_out_low_in_reset_r1: assert property (@(posedge clk)
    !srst_n |-> !bit_out);
  // R7: with dither off the quantiser offset is zero
  p_no_dither_when_off_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !dither_en |-> dith == '0);

endmodule

// File: tb/pcm_bitstream_mod_tb.sv
module pcm_bitstream_mod_tb;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              sample_en;
  logic signed [15:0] sample_in;
  logic              dither_en;
  logic              bo1, bo2;

  always #2 clk = ~clk;  // 250 MHz

  pcm_bitstream_mod #(.DATA_W(16), .ORDER(2), .DITH_BITS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_in(sample_in),
    .dither_en(dither_en), .bit_out(bo2));

  pcm_bitstream_mod #(.DATA_W(16), .ORDER(1), .DITH_BITS(4)) u_dut_o1 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample_in(sample_in),
    .dither_en(dither_en), .bit_out(bo1));

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- reference model built from R1..R7 ----------------
  logic        m_r1, m_r2;
  longint      m_h, a1, b1, b2;
  logic        abit, bbit;
  logic [15:0] lf;
  longint      t1, t2, tb1, fa, fbb, dd;

  function automatic longint clipl(input longint v, input longint lo, input longint hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_r1 <= 1'b0; m_r2 <= 1'b0; end
    else        begin m_r1 <= 1'b1; m_r2 <= m_r1; end
  end

  always @(posedge clk) begin
    if (!m_r2) begin
      m_h <= 0; a1 <= 0; b1 <= 0; b2 <= 0; abit <= 1'b0; bbit <= 1'b0; lf <= 16'hACE1;
    end else begin
      dd  = dither_en ? (lf[3] ? longint'(lf[3:0]) - 16 : longint'(lf[3:0])) : 0;
      fa  = abit ? 32768 : -32768;
      t1  = clipl(a1 + m_h - fa, -131072, 131071);
      a1   <= t1;
      abit <= (t1 + dd) >= 0;
      fbb = bbit ? 32768 : -32768;
      tb1 = clipl(b1 + m_h - fbb, -131072, 131071);
      t2  = clipl(b2 + tb1 - fbb, -262144, 262143);
      b1   <= tb1;
      b2   <= t2;
      bbit <= (t2 + dd) >= 0;
      lf   <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (sample_en) m_h <= longint'(sample_in);
    end
  end

  // ---------------- stepping, comparing, counting ----------------
  bit cmp_on = 1'b0;
  int mis1, mis2, ones1, ones2;

  task automatic step(input bit count);
    @(negedge clk);
    if (cmp_on) begin
      if (bo1 !== abit) mis1++;
      if (bo2 !== bbit) mis2++;
    end
    if (count) begin
      ones1 += int'(bo1);
      ones2 += int'(bo2);
    end
  endtask

  // {dither, scramble-between-strobes, sample}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000},
    {1'b0, 1'b0, 16'h4000},
    {1'b0, 1'b1, 16'hC000},
    {1'b0, 1'b0, 16'h1F40},
    {1'b0, 1'b1, 16'hD120},
    {1'b1, 1'b0, 16'h03E8},
    {1'b1, 1'b1, 16'hEC78},
    {1'b0, 1'b1, 16'h7530},
    {1'b0, 1'b0, 16'h8000},
    {1'b1, 1'b0, 16'h7FFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sample_en = 1'b1; sample_in = 16'sh7FFF; dither_en = 1'b1;
    // R1: output low during reset even with a strobe and a large sample present
    repeat (4) begin
      step(1'b0);
      chk(bo1 == 1'b0 && bo2 == 1'b0, "R1 low in reset", {bo2, bo1}, 0);
    end
    sample_en = 1'b0; sample_in = 16'sh0000; dither_en = 1'b0;
    rst_n = 1'b1;
    // R1: still low on the two edges after release
    repeat (2) begin
      step(1'b0);
      chk(bo1 == 1'b0 && bo2 == 1'b0, "R1 low after release", {bo2, bo1}, 0);
    end
    cmp_on = 1'b1;

    for (int v = 0; v < NV; v++) begin
      longint x;
      x = longint'($signed(VEC[v][15:0]));
      mis1 = 0; mis2 = 0;
      sample_in = VEC[v][15:0]; sample_en = 1'b1; dither_en = VEC[v][17];
      step(1'b0);
      sample_en = 1'b0;
      for (int c = 0; c < 256; c++) begin
        step(1'b0);
        if (VEC[v][16]) sample_in = 16'($urandom);
      end
      ones1 = 0; ones2 = 0;
      for (int c = 0; c < 4096; c++) begin
        step(1'b1);
        if (VEC[v][16]) sample_in = 16'($urandom);
      end
      // R3 R4 R5 R6 R7 R2: bit-exact stream versus the model
      chk(mis1 == 0, $sformatf("R3/R2 order-1 stream vec %0d", v), mis1, 0);
      chk(mis2 == 0, $sformatf("R4/R5 order-2 stream vec %0d", v), mis2, 0);
      // R8: average duty over 4096 bits
      chk((16 * ones1 - (x + 32768)) <= 96 && (16 * ones1 - (x + 32768)) >= -96,
          $sformatf("R8 order-1 ones vec %0d", v), ones1, (x + 32768) / 16);
      if (x <= 16384 && x >= -16384)
        chk((16 * ones2 - (x + 32768)) <= 96 && (16 * ones2 - (x + 32768)) >= -96,
            $sformatf("R8 order-2 ones vec %0d", v), ones2, (x + 32768) / 16);
    end

    // R1: reset in the middle of a run clears the pin at once and restarts cleanly
    sample_in = 16'sh4000; sample_en = 1'b1; dither_en = 1'b1;
    step(1'b0);
    sample_en = 1'b0;
    repeat (20) step(1'b0);
    rst_n = 1'b0;
    cmp_on = 1'b0;
    #1;
    chk(bo1 == 1'b0 && bo2 == 1'b0, "R1 async clear mid-run", {bo2, bo1}, 0);
    repeat (3) step(1'b0);
    sample_in = 16'sh1388; sample_en = 1'b1;
    rst_n = 1'b1;
    step(1'b0);
    chk(bo1 == 1'b0 && bo2 == 1'b0, "R1 low first edge after release", {bo2, bo1}, 0);
    step(1'b0);
    chk(bo1 == 1'b0 && bo2 == 1'b0, "R1 low second edge after release", {bo2, bo1}, 0);
    sample_en = 1'b0;
    mis1 = 0; mis2 = 0;
    cmp_on = 1'b1;
    repeat (600) step(1'b0);
    chk(mis1 == 0 && mis2 == 0, "R1/R6 restart stream with dither", mis1 + mis2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule